// File: doc/BRIEF.md
# ALU Status Flag Generator

This block is a small integer execution unit for add, add-with-carry, subtract, subtract-with-borrow, AND, OR and XOR. It works on byte, half-word or full-word operands. Each accepted operation registers a result and a six-bit status word: carry or borrow, parity, nibble carry, zero, sign and overflow. The operand size picks where the carry, overflow and sign are taken and which result bits are kept.

The caller presents an opcode, two operands, a size code and a carry input together with a one-cycle valid strobe. Result and flags are visible from the clock edge that samples the strobe. A per-bit set mask and a per-bit clear mask let software write single status bits directly. A direct write wins over the flags of an operation issued in the same cycle.

With the default `DATA_W` of 32, the three sizes are 8, 16 and 32 bits. In general they are a quarter of the word, half of the word and the whole word.

Top module: `alu_flag_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `result` and `flags` become zero on that edge.
- R2: With `op_valid` high, the opcode encodings are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 OR, 6 XOR, 7 no operation. The size encodings are 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits. For codes 0 to 3, `result` becomes `opa op opb` on the next edge, computed on operands cut to the size, with `carry_in` added (code 1) or subtracted (code 3). All result bits above the size are zero.
- R3: Codes 4 to 6 produce the bitwise result at the size, with upper bits zero. They clear carry (bit 0), nibble carry (bit 2) and overflow (bit 5).
- R4: Flag bit 0 (carry) is set when the unsigned sum does not fit in the size, or when a subtraction needs a borrow (`opa < opb + borrow-in`).
- R5: Flag bit 5 (overflow) is set when the signed result of an arithmetic code does not fit in the size.
- R6: Flag bit 4 (sign) equals the result bit at position size-1. Flag bit 3 (zero) is set when the sized result is all zeros.
- R7: Flag bit 2 (nibble carry) is set when an arithmetic code carries or borrows from bit 3 into bit 4.
- R8: Flag bit 1 (parity) is set when result bits 7:0 hold an even number of ones, at every size.
- R9: With `op_valid` low, or with opcode 7, `result` keeps its value. In those cases `flags` also keeps its value unless a direct write is present.
- R10: When any bit of `flag_set` or `flag_clr` is high, `flags` becomes `(flags | flag_set) & ~flag_clr` on the next edge. A clear therefore wins over a set on the same bit, and the flags of an operation in that cycle are discarded. The operation's `result` is still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation select |
| op_size | input | 2 | Operand size select |
| opa | input | DATA_W | First operand |
| opb | input | DATA_W | Second operand |
| carry_in | input | 1 | Carry or borrow input for codes 1 and 3 |
| flag_set | input | 6 | Per-bit direct set of the flags |
| flag_clr | input | 6 | Per-bit direct clear of the flags |
| result | output | DATA_W | Registered result |
| flags | output | 6 | Registered status flags |

## Verification
Every internal fault in the block shows on the first edge after the faulty operation, because both outputs are registers loaded straight from the operation path:
- A wrong size mask shows as set upper result bits, or as a carry, sign or overflow taken from the wrong bit.
- A wrong carry chain shows in the carry, nibble-carry or overflow bit.
- A wrong priority between direct write and operation shows as operation flags where the written mask was due.

The bench compares result and each flag bit separately after every cycle. It mixes random operands with boundary values at all three sizes.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int FLAG_N  = 6;
  localparam int FL_CARRY = 0;
  localparam int FL_PAR   = 1;
  localparam int FL_AUX   = 2;
  localparam int FL_ZERO  = 3;
  localparam int FL_SIGN  = 4;
  localparam int FL_OVF   = 5;
  localparam int NSIZE    = 3;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_NOP = 3'd7
  } alu_op_e;
endpackage

// File: rtl/alu_size_dec.sv
module alu_size_dec #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] msb_sel
);
  import alu_flag_pkg::*;
  localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] LSB  = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] mask_t [NSIZE];
  logic [DATA_W-1:0] msb_t  [NSIZE];
  logic [1:0]        idx;

  for (genvar g = 0; g < NSIZE; g++) begin : g_size
    localparam int SW = DATA_W >> (NSIZE - 1 - g);
    assign mask_t[g] = ONES >> (DATA_W - SW);
    assign msb_t[g]  = LSB << (SW - 1);
  end

  always_comb begin
    idx     = (size == 2'd3) ? 2'd2 : size;
    mask    = mask_t[idx];
    msb_sel = msb_t[idx];
  end
endmodule

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        code,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] msb_sel,
  output logic [DATA_W-1:0] res,
  output logic              cf,
  output logic              of,
  output logic              af
);
  import alu_flag_pkg::*;
  logic [DATA_W-1:0] am, bm;
  logic [DATA_W:0]   ext, xv;
  logic              cin_eff, is_sub, is_logic, c_msb_in;

  always_comb begin
    am       = a & mask;
    bm       = b & mask;
    is_sub   = (code == OP_SUB) || (code == OP_SBB);
    is_logic = (code == OP_AND) || (code == OP_OR) || (code == OP_XOR);
    cin_eff  = ((code == OP_ADC) || (code == OP_SBB)) ? cin : 1'b0;
    if (is_sub)
      ext = {1'b0, am} - {1'b0, bm} - {{DATA_W{1'b0}}, cin_eff};
    else
      ext = {1'b0, am} + {1'b0, bm} + {{DATA_W{1'b0}}, cin_eff};
    // xv[i] is the carry (or borrow) entering bit i
    xv       = {1'b0, am} ^ {1'b0, bm} ^ ext;
    c_msb_in = |(xv[DATA_W-1:0] & msb_sel);
    res      = ext[DATA_W-1:0] & mask;
    cf       = |(xv[DATA_W:1] & msb_sel);
    of       = cf ^ c_msb_in;
    af       = xv[4];
    if (is_logic) begin
      cf = 1'b0;
      of = 1'b0;
      af = 1'b0;
      unique case (code)
        OP_AND:  res = am & bm;
        OP_OR:   res = am | bm;
        default: res = am ^ bm;
      endcase
    end
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           upd,
  input  logic [alu_flag_pkg::FLAG_N-1:0] new_flags,
  input  logic [alu_flag_pkg::FLAG_N-1:0] set_m,
  input  logic [alu_flag_pkg::FLAG_N-1:0] clr_m,
  output logic [alu_flag_pkg::FLAG_N-1:0] flags_q
);
  always_ff @(posedge clk) begin
    if (rst)
      flags_q <= '0;
    else if ((|set_m) || (|clr_m))
      flags_q <= (flags_q | set_m) & ~clr_m;
    else if (upd)
      flags_q <= new_flags;
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int DATA_W = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            op_valid,
  input  logic [2:0]                      op_code,
  input  logic [1:0]                      op_size,
  input  logic [DATA_W-1:0]               opa,
  input  logic [DATA_W-1:0]               opb,
  input  logic                            carry_in,
  input  logic [alu_flag_pkg::FLAG_N-1:0] flag_set,
  input  logic [alu_flag_pkg::FLAG_N-1:0] flag_clr,
  output logic [DATA_W-1:0]               result,
  output logic [alu_flag_pkg::FLAG_N-1:0] flags
);
  import alu_flag_pkg::*;
  logic [DATA_W-1:0] mask, msb_sel, res_c;
  logic              cf_c, of_c, af_c, fire;
  logic [FLAG_N-1:0] flags_c;

  alu_size_dec #(.DATA_W(DATA_W)) u_size (
    .size(op_size), .mask(mask), .msb_sel(msb_sel)
  );

  alu_arith #(.DATA_W(DATA_W)) u_arith (
    .code(op_code), .a(opa), .b(opb), .cin(carry_in),
    .mask(mask), .msb_sel(msb_sel),
    .res(res_c), .cf(cf_c), .of(of_c), .af(af_c)
  );

  always_comb begin
    fire              = op_valid && (op_code != OP_NOP);
    flags_c           = '0;
    flags_c[FL_CARRY] = cf_c;
    flags_c[FL_PAR]   = ~^res_c[7:0];
    flags_c[FL_AUX]   = af_c;
    flags_c[FL_ZERO]  = ~|res_c;
    flags_c[FL_SIGN]  = |(res_c & msb_sel);
    flags_c[FL_OVF]   = of_c;
  end

  alu_flag_reg u_freg (
    .clk(clk), .rst(rst), .upd(fire), .new_flags(flags_c),
    .set_m(flag_set), .clr_m(flag_clr), .flags_q(flags)
  );

  always_ff @(posedge clk) begin
    if (rst)
      result <= '0;
    else if (fire)
      result <= res_c;
  end
endmodule

// File: rtl/alu_flag_chk.sv
module alu_flag_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [2:0]        op_code,
  input logic [1:0]        op_size,
  input logic [5:0]        flag_set,
  input logic [5:0]        flag_clr,
  input logic [DATA_W-1:0] result,
  input logic [5:0]        flags
);
  localparam int QW = DATA_W / 4;
  logic no_wr, acc, is_logic;
  assign no_wr    = (flag_set == 6'd0) && (flag_clr == 6'd0);
  assign acc      = op_valid && (op_code != 3'd7) && no_wr;
  assign is_logic = (op_code == 3'd4) || (op_code == 3'd5) || (op_code == 3'd6);

  function automatic logic msb_of(input logic [DATA_W-1:0] r, input logic [1:0] s);
    case (s)
      2'd0:    msb_of = r[QW-1];
      2'd1:    msb_of = r[DATA_W/2-1];
      default: msb_of = r[DATA_W-1];
    endcase
  endfunction

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (result == '0) && (flags == 6'd0));

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code != 3'd7 && op_size == 2'd0) |=> (result[DATA_W-1:QW] == '0));

  assert_logic_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (acc && is_logic) |=> (!flags[0] && !flags[2] && !flags[5]));

  assert_zero_R6: assert property (@(posedge clk) disable iff (rst)
    acc |=> (flags[3] == (result == '0)));

  assert_sign_R6: assert property (@(posedge clk) disable iff (rst)
    acc |=> (flags[4] == msb_of(result, $past(op_size))));

  assert_parity_R8: assert property (@(posedge clk) disable iff (rst)
    acc |=> (flags[1] == ~^result[7:0]));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    ((!op_valid || op_code == 3'd7) && no_wr) |=> ($stable(result) && $stable(flags)));

  assert_direct_R10: assert property (@(posedge clk) disable iff (rst)
    !no_wr |=> (flags == (($past(flags) | $past(flag_set)) & ~$past(flag_clr))));
endmodule

bind alu_flag_unit alu_flag_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .op_size(op_size), .flag_set(flag_set), .flag_clr(flag_clr),
  .result(result), .flags(flags)
);

// File: tb/test_alu_flag_unit.sv
module test_alu_flag_unit;
  localparam int W = 32;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [2:0] op_code = '0;
  logic [1:0] op_size = '0;
  logic [W-1:0] opa = '0, opb = '0;
  logic carry_in = 1'b0;
  logic [5:0] flag_set = '0, flag_clr = '0;
  logic [W-1:0] result;
  logic [5:0] flags;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [W-1:0] exp_res = '0;
  logic [5:0]   exp_flags = '0;

  always #5 clk = ~clk;

  alu_flag_unit #(.DATA_W(W)) i_alu_flag_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_size(op_size), .opa(opa), .opb(opb), .carry_in(carry_in),
    .flag_set(flag_set), .flag_clr(flag_clr), .result(result), .flags(flags)
  );

  function automatic void model(input logic [2:0] code, input logic [1:0] sz,
                                input logic [W-1:0] a, input logic [W-1:0] b,
                                input logic c, output logic [W-1:0] r,
                                output logic [5:0] f);
    int n;
    logic [63:0] mask, am, bm, s, cc;
    logic sa, sb, sr;
    n    = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    mask = (64'd1 << n) - 64'd1;
    am   = {32'd0, a} & mask;
    bm   = {32'd0, b} & mask;
    cc   = (code == 3'd1 || code == 3'd3) ? {63'd0, c} : 64'd0;
    f    = '0;
    case (code)
      3'd0, 3'd1: begin
        s = am + bm + cc;
        f[0] = s[n];
      end
      3'd2, 3'd3: begin
        s = am - bm - cc;
        f[0] = (am < bm + cc);
      end
      3'd4: s = am & bm;
      3'd5: s = am | bm;
      default: s = am ^ bm;
    endcase
    s  = s & mask;
    r  = s[W-1:0];
    sa = am[n-1]; sb = bm[n-1]; sr = s[n-1];
    if (code <= 3'd3) begin
      f[2] = am[4] ^ bm[4] ^ s[4];
      if (code <= 3'd1) f[5] = (sa == sb) && (sr != sa);
      else              f[5] = (sa != sb) && (sr != sa);
    end else begin
      f[0] = 1'b0;
    end
    f[1] = ~^s[7:0];
    f[3] = (s == 64'd0);
    f[4] = sr;
  endfunction

  task automatic check(input logic [W-1:0] got, input logic [W-1:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // drive at a falling edge, the design samples at the next rising edge,
  // outputs are compared at the following falling edge
  task automatic step(input logic v, input logic [2:0] code, input logic [1:0] sz,
                      input logic [W-1:0] a, input logic [W-1:0] b, input logic c,
                      input logic [5:0] st, input logic [5:0] cl);
    logic [W-1:0] mr;
    logic [5:0]   mf;
    bit direct, fire;
    op_valid = v; op_code = code; op_size = sz; opa = a; opb = b;
    carry_in = c; flag_set = st; flag_clr = cl;
    model(code, sz, a, b, c, mr, mf);
    direct = (st != 6'd0) || (cl != 6'd0);
    fire   = v && (code != 3'd7);
    @(negedge clk);
    if (fire) exp_res = mr;
    if (direct)    exp_flags = (exp_flags | st) & ~cl;
    else if (fire) exp_flags = mf;
    if (!fire)
      check(result, exp_res, "R9 result hold");
    else if (code >= 3'd4)
      check(result, exp_res, "R3 logic result");
    else
      check(result, exp_res, "R2 arith result");
    if (direct)
      check({26'd0, flags}, {26'd0, exp_flags}, "R10 direct write");
    else if (!fire)
      check({26'd0, flags}, {26'd0, exp_flags}, "R9 flags hold");
    else begin
      check({31'd0, flags[0]}, {31'd0, exp_flags[0]}, (code >= 3'd4) ? "R3 carry" : "R4 carry");
      check({31'd0, flags[1]}, {31'd0, exp_flags[1]}, "R8 parity");
      check({31'd0, flags[2]}, {31'd0, exp_flags[2]}, (code >= 3'd4) ? "R3 aux" : "R7 aux");
      check({31'd0, flags[3]}, {31'd0, exp_flags[3]}, "R6 zero");
      check({31'd0, flags[4]}, {31'd0, exp_flags[4]}, "R6 sign");
      check({31'd0, flags[5]}, {31'd0, exp_flags[5]}, (code >= 3'd4) ? "R3 overflow" : "R5 overflow");
    end
  endtask

  function automatic logic [W-1:0] pick();
    logic [W-1:0] edges [10] = '{32'h0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000,
                                 32'h7F, 32'h80, 32'h7FFF, 32'h8000, 32'hFF, 32'hFFFF};
    if ($urandom_range(3) == 0) pick = edges[$urandom_range(9)];
    else                        pick = $urandom;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    check(result, '0, "R1 reset result");
    check({26'd0, flags}, 32'd0, "R1 reset flags");
    rst = 1'b0;
    // R5 R7: signed overflow and nibble carry at 8 bits
    step(1, 3'd0, 2'd0, 32'hAAAA_AA7F, 32'h5555_5501, 0, 0, 0);
    // R4 R6: carry out and zero at 16 bits
    step(1, 3'd0, 2'd1, 32'h1234_FFFF, 32'h0000_0001, 0, 0, 0);
    // R4: borrow at 32 bits
    step(1, 3'd2, 2'd2, 32'h0, 32'h1, 0, 0, 0);
    // R2: add with carry input
    step(1, 3'd1, 2'd0, 32'hFF, 32'h0, 1, 0, 0);
    // R5: subtract with borrow crosses the signed limit
    step(1, 3'd3, 2'd0, 32'h80, 32'h0, 1, 0, 0);
    // R2: size code 3 acts as full width
    step(1, 3'd0, 2'd3, 32'hFFFF_FFFF, 32'h1, 0, 0, 0);
    // R3: logic op with junk above the size
    step(1, 3'd4, 2'd0, 32'hFFFF_FF0F, 32'hABCD_EFF3, 1, 0, 0);
    // R8: parity on low byte only at 32 bits
    step(1, 3'd6, 2'd2, 32'h0100_0003, 32'h0, 0, 0, 0);
    // R9: reserved opcode and idle cycle
    step(1, 3'd7, 2'd0, 32'h1, 32'h1, 0, 0, 0);
    step(0, 3'd0, 2'd0, 32'h5, 32'h5, 0, 0, 0);
    // R10: direct set during an op, then clear beats set
    step(1, 3'd0, 2'd2, 32'h1, 32'h1, 0, 6'h3F, 0);
    step(1, 3'd2, 2'd1, 32'h5, 32'h5, 0, 6'h21, 6'h01);
    step(0, 3'd0, 2'd0, 32'h0, 32'h0, 0, 0, 6'h10);
    for (int i = 0; i < 600; i++) begin
      logic [5:0] st, cl;
      st = ($urandom_range(9) == 0) ? 6'($urandom) : 6'd0;
      cl = ($urandom_range(9) == 0) ? 6'($urandom) : 6'd0;
      step($urandom_range(7) != 0, 3'($urandom), 2'($urandom), pick(), pick(),
           1'($urandom), st, cl);
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule